// File: doc/BRIEF.md
# Pause-Referenced Response Trigger Timer

This block produces the trigger that starts a card's reply when the reply delay is counted from the end of the reader's most recent modulation pause rather than from a fixed bit grid. It runs on the carrier clock and watches the demodulated reader signal. That signal is high while the field is unmodulated and low during a pause. The signal first passes through a two-flop synchronizer. Every edge of the synchronized signal restarts a 16-bit cycle counter. After a rising edge, which marks the end of a pause, the timer sends a one-cycle start strobe to the response serializer when the counter equals compare value A.

A second output, `aux_o`, is set by each falling edge, which marks the start of a pause. It clears when the counter reaches compare value B. The block is armed with `arm_i`. The two compare values can only be written while the block is disarmed. Because each rising edge moves the reference point, the strobe is always timed from the last pause end that the reader sent.

Top module: `resp_timer`

## Requirements
- R1: During and directly after reset, `start_o` and `aux_o` are both 0.
- R2: When armed, a low-to-high change of `pause_i` produces exactly one `start_o` pulse, one clock long. It is high in the clock cycle that begins at the (A+4)-th rising clock edge after the change (A = compare value A). With A = 0 the pulse begins at the 4th edge.
- R3: The counter stops at all-ones and does not wrap. After a strobe, no further strobe occurs until another rising edge of `pause_i`, even after more than 65536 cycles.
- R4: A falling edge of `pause_i` before a pending strobe cancels that strobe. The next strobe is timed only from the latest rising edge.
- R5: While `pause_i` is held low, no strobe is produced, however long the pause lasts.
- R6: When armed, a high-to-low change of `pause_i` makes `aux_o` go to 1 at the 3rd rising clock edge after the change. `aux_o` stays 1 for B+1 cycles and returns to 0 at edge B+4 (B = compare value B), provided no other edge of `pause_i` occurs in that window.
- R7: While `arm_i` is 0, `start_o` and `aux_o` stay 0 and the counter is held at zero. Setting `arm_i` again produces no strobe until a new rising edge of `pause_i`.
- R8: `cmp_a_i` and `cmp_b_i` are captured at a clock edge where `load_i` is 1 and `arm_i` is 0. Any load while `arm_i` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Carrier clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Enables the timer; when 0, the outputs and the counter are cleared |
| load_i | input | 1 | Writes the compare values while disarmed |
| cmp_a_i | input | 16 | Strobe delay value A, in carrier cycles |
| cmp_b_i | input | 16 | Clear point B for aux_o, in carrier cycles |
| pause_i | input | 1 | Asynchronous demodulated reader signal, low during a pause |
| start_o | output | 1 | One-cycle frame-start strobe to the serializer |
| aux_o | output | 1 | Auxiliary pulse, set by a pause start and cleared at compare B |

## Verification
The assertions assume that `pause_i` pauses last long enough that an edge survives the synchronizer. They also assume that compare values change only through `load_i`. The stimulus changes `pause_i` only at falling clock edges and holds each level for at least six cycles. The pause-width checks keep every pause longer than B+4 cycles, so the clear of `aux_o` is seen before the rising edge restarts the count. Loads are applied while disarmed, except in the one test where a load during armed operation is meant to be ignored.

// File: rtl/resp_timer_pkg.sv
package resp_timer_pkg;
    localparam int TIMER_W = 16;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;
endpackage

// File: rtl/resp_timer_sync.sv
module resp_timer_sync
    import resp_timer_pkg::*;
#(
    parameter bit IDLE_LVL = 1'b1
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  async_i,
    output edge_t edge_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = async_i;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
        edge_o.rise = sync_q.s2 & ~sync_q.prev;
        edge_o.fall = ~sync_q.s2 & sync_q.prev;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '{s1: IDLE_LVL, s2: IDLE_LVL, prev: IDLE_LVL};
        end else begin
            sync_q <= sync_d;
        end
    end
endmodule

// File: rtl/resp_timer_cmp.sv
module resp_timer_cmp #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         arm_i,
    input  logic         load_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o
);
    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
    } cmp_t;

    cmp_t cmp_d, cmp_q;

    always_comb begin
        cmp_d = cmp_q;
        if (load_i && !arm_i) begin
            cmp_d.a = a_i;
            cmp_d.b = b_i;
        end
        a_o = cmp_q.a;
        b_o = cmp_q.b;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cmp_q <= '{a: {W{1'b1}}, b: {W{1'b1}}};
        end else begin
            cmp_q <= cmp_d;
        end
    end
endmodule

// File: rtl/resp_timer_core.sv
module resp_timer_core
    import resp_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         arm_i,
    input  edge_t        edge_i,
    input  logic [W-1:0] cmp_a_i,
    input  logic [W-1:0] cmp_b_i,
    output logic         start_o,
    output logic         aux_o,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pend;
        logic         start;
        logic         aux;
    } core_t;

    core_t core_d, core_q;
    logic  any_edge;
    logic  hit_a;
    logic  hit_b;

    always_comb begin
        core_d   = core_q;
        any_edge = edge_i.rise | edge_i.fall;
        hit_a    = arm_i && core_q.pend && !any_edge && (core_q.cnt == cmp_a_i);
        hit_b    = !any_edge && (core_q.cnt == cmp_b_i);

        core_d.start = hit_a;

        if (!arm_i) begin
            core_d.cnt  = '0;
            core_d.pend = 1'b0;
            core_d.aux  = 1'b0;
        end else begin
            if (any_edge) begin
                core_d.cnt = '0;
            end else if (core_q.cnt != CNT_MAX) begin
                core_d.cnt = core_q.cnt + 1'b1;
            end

            if (edge_i.rise) begin
                core_d.pend = 1'b1;
            end else if (edge_i.fall || hit_a) begin
                core_d.pend = 1'b0;
            end

            if (edge_i.fall) begin
                core_d.aux = 1'b1;
            end else if (hit_b) begin
                core_d.aux = 1'b0;
            end
        end

        start_o = core_q.start;
        aux_o   = core_q.aux;
        cnt_o   = core_q.cnt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end
endmodule

// File: rtl/resp_timer.sv
module resp_timer
    import resp_timer_pkg::*;
#(
    parameter int W = TIMER_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         arm_i,
    input  logic         load_i,
    input  logic [W-1:0] cmp_a_i,
    input  logic [W-1:0] cmp_b_i,
    input  logic         pause_i,
    output logic         start_o,
    output logic         aux_o
);
    edge_t        edge_w;
    logic         rise_w;
    logic         fall_w;
    logic [W-1:0] cmp_a_w;
    logic [W-1:0] cmp_b_w;
    logic [W-1:0] cnt_w;

    assign rise_w = edge_w.rise;
    assign fall_w = edge_w.fall;

    resp_timer_sync #(.IDLE_LVL(1'b1)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pause_i),
        .edge_o  (edge_w)
    );

    resp_timer_cmp #(.W(W)) u_cmp (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .arm_i  (arm_i),
        .load_i (load_i),
        .a_i    (cmp_a_i),
        .b_i    (cmp_b_i),
        .a_o    (cmp_a_w),
        .b_o    (cmp_b_w)
    );

    resp_timer_core #(.W(W)) u_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .arm_i   (arm_i),
        .edge_i  (edge_w),
        .cmp_a_i (cmp_a_w),
        .cmp_b_i (cmp_b_w),
        .start_o (start_o),
        .aux_o   (aux_o),
        .cnt_o   (cnt_w)
    );
endmodule

// File: rtl/resp_timer_chk.sv
module resp_timer_chk #(
    parameter int W = 16
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         arm_i,
    input logic         start_o,
    input logic         aux_o,
    input logic         rise_w,
    input logic         fall_w,
    input logic [W-1:0] cnt_w,
    input logic [W-1:0] cmp_a_w,
    input logic [W-1:0] cmp_b_w
);
    // R2
    strobe_at_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |-> $past(cnt_w == cmp_a_w));

    // R2
    strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o);

    // R4
    fall_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_w |=> !start_o);

    // R4
    edge_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_w || fall_w) |=> (cnt_w == '0));

    // R3
    cnt_saturate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm_i && (cnt_w == {W{1'b1}}) && !rise_w && !fall_w) |=> (cnt_w == {W{1'b1}}));

    // R6
    aux_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm_i && fall_w) |=> aux_o);

    // R7
    disarm_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !arm_i |=> (!start_o && !aux_o && (cnt_w == '0)));

    // R8
    cmp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i |=> ($stable(cmp_a_w) && $stable(cmp_b_w)));
endmodule

bind resp_timer resp_timer_chk #(.W(W)) u_resp_timer_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm_i),
    .start_o (start_o),
    .aux_o   (aux_o),
    .rise_w  (rise_w),
    .fall_w  (fall_w),
    .cnt_w   (cnt_w),
    .cmp_a_w (cmp_a_w),
    .cmp_b_w (cmp_b_w)
);

// File: tb/test_resp_timer.sv
`timescale 1ns/1ps
module test_resp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic        load = 1'b0;
    logic [15:0] cmp_a = '0;
    logic [15:0] cmp_b = '0;
    logic        pause = 1'b1;
    logic        start;
    logic        aux;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    resp_timer i_resp_timer (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .arm_i   (arm),
        .load_i  (load),
        .cmp_a_i (cmp_a),
        .cmp_b_i (cmp_b),
        .pause_i (pause),
        .start_o (start),
        .aux_o   (aux)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops the expected strobe cycle for every strobe seen (R2, R3, R4, R5, R7)
    always @(negedge clk) begin : mon
        int e;
        if (rst_n && start) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R5/R7", "unexpected start_o at cycle", cyc, -1);
            end else begin
                e = exp_q.pop_front();
                check(e == cyc, "R2/R4", "start_o cycle", cyc, e);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cmp(input int a, input int b);
        @(negedge clk);
        arm = 1'b0; load = 1'b1; cmp_a = 16'(a); cmp_b = 16'(b);
        @(negedge clk);
        load = 1'b0; arm = 1'b1;
    endtask

    // Pause of len cycles; queue a strobe A+4 edges after the rise if expected
    task automatic do_pause(input int len, input bit strobe_exp, input int a);
        @(negedge clk);
        pause = 1'b0;
        repeat (len) @(negedge clk);
        pause = 1'b1;
        if (strobe_exp) exp_q.push_back(cyc + a + 4);
    endtask

    // Pause with aux_o width checks (R6); len must exceed b+4
    task automatic aux_pause(input int b, input int len, input int a);
        int c0;
        @(negedge clk);
        pause = 1'b0;
        c0 = cyc;
        idle(2);
        check(aux == 1'b0, "R6", "aux_o before set", aux, 0);
        idle(1);
        check(aux == 1'b1, "R6", "aux_o set at edge 3", aux, 1);
        idle(b);
        check(aux == 1'b1, "R6", "aux_o at last high cycle", aux, 1);
        idle(1);
        check(aux == 1'b0, "R6", "aux_o cleared at edge B+4", aux, 0);
        idle(len - (cyc - c0));
        pause = 1'b1;
        exp_q.push_back(cyc + a + 4);
    endtask

    initial begin
        idle(5);
        check(start == 1'b0, "R1", "start_o in reset", start, 0);
        check(aux == 1'b0, "R1", "aux_o in reset", aux, 0);
        rst_n = 1'b1;
        idle(2);
        check(start == 1'b0, "R1", "start_o after reset", start, 0);
        check(aux == 1'b0, "R1", "aux_o after reset", aux, 0);

        // R2 and R6: basic strobe and aux pulse
        set_cmp(20, 5);
        aux_pause(5, 12, 20);
        idle(40);

        // R4: second pause before pending strobe cancels first
        do_pause(8, 1'b0, 20);
        idle(10);
        do_pause(8, 1'b1, 20);
        idle(40);

        // R5: long held pause gives no strobe until it ends
        do_pause(100, 1'b1, 20);
        idle(40);

        // R3: no repeat past a full counter range
        idle(70000);

        // R2 boundary A=0, R6 boundary B=0
        set_cmp(0, 0);
        aux_pause(0, 8, 0);
        idle(20);

        // R8: load while armed is ignored, load while disarmed takes effect
        set_cmp(30, 3);
        @(negedge clk);
        load = 1'b1; cmp_a = 16'd7; cmp_b = 16'd1;
        @(negedge clk);
        load = 1'b0;
        aux_pause(3, 10, 30);
        idle(50);
        set_cmp(7, 3);
        do_pause(6, 1'b1, 7);
        idle(30);

        // R7: disarmed pause gives nothing, re-arming alone gives nothing
        @(negedge clk);
        arm = 1'b0;
        @(negedge clk);
        pause = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(aux == 1'b0, "R7", "aux_o while disarmed", aux, 0);
        end
        pause = 1'b1;
        idle(40);
        arm = 1'b1;
        idle(60);
        check(start == 1'b0, "R7", "start_o after re-arm", start, 0);

        check(exp_q.size() == 0, "R2", "missing strobes", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule